// File: doc/BRIEF.md
# Two-Wire Parallel-In Serial-Out Input Expander

This block lets a host read a 12-bit parallel input word over just two signals: a serial clock line driven by the host and one shared line whose direction turns around during the exchange. In input mode the host uses the shared line as a capture strobe. It holds the serial clock high and pulls the shared line from high to low. The block then latches the parallel word, takes over the shared line, and drives it low.

Each later falling edge of the serial clock moves one captured bit onto the shared line, lowest bit first. The thirteenth falling edge since the capture returns the shared line to input mode, with the output enable deasserted. The pins are modelled as a tri-state pair: the resolved line value comes in, and an output value and an output enable go out. Both pin inputs are brought into a fast system clock domain through synchronizers, and every edge is detected there.

The control core is a two-state machine. In state ST_LISTEN the block does not drive the line. In state ST_SEND it drives the line. Transition T_CAPTURE moves from ST_LISTEN to ST_SEND on a valid strobe. Transition T_RELEASE moves from ST_SEND to ST_LISTEN on the falling clock edge that the saturating edge counter marks as the last one. Any run of thirteen falling clock edges forces the block into ST_LISTEN, whatever its starting point.

Top module: `pio_serial_expander`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the output enable is low and the serial output value is 0 (state ST_LISTEN).
- R2: In ST_LISTEN, a high-to-low transition of the shared line while the serial clock is high captures the parallel word and asserts the output enable within 4 system cycles (transition T_CAPTURE).
- R3: Right after a capture, the block drives the shared line to 0 until the first falling serial clock edge.
- R4: The k-th falling serial clock edge after a capture (k = 1 to 12) puts captured bit k-1 on the shared line, so bit 0 comes first in ascending order.
- R5: The 13th falling serial clock edge after a capture deasserts the output enable (transition T_RELEASE). Edges 1 to 12 leave the output enable asserted.
- R6: While in ST_SEND, falling edges of the shared line are never taken as capture strobes, and changes on the parallel inputs after the capture have no effect on the bits sent.
- R7: A high-to-low transition of the shared line while the serial clock is low does not capture and leaves the output enable low.
- R8: From any point in a transfer, 13 consecutive falling serial clock edges leave the block in ST_LISTEN. Falling clock edges in ST_LISTEN never assert the output enable.
- R9: The falling-edge counter is cleared by a capture, counts each falling serial clock edge, and saturates at 13.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to sample the pins |
| rst_i | input | 1 | Synchronous reset, active high |
| par_i | input | 12 | Parallel input word, bit 0 is sent first |
| sclk_pin_i | input | 1 | Serial clock line from the host |
| sline_pin_i | input | 1 | Resolved level of the shared strobe/data line |
| sline_pin_o | output | 1 | Value the block drives onto the shared line |
| sline_oe_o | output | 1 | Output enable for the shared line, high in ST_SEND |

## Verification
The hardest case to reach from the ports is the unknown starting direction, where the block may be part way through a transfer when the host begins clocking. The bench creates this on purpose. It captures a word, stops after every possible number of sent bits from 0 to 12, then applies thirteen clock falls and checks that the line has been released and that a fresh capture still works. Each transfer also changes the parallel inputs in mid-stream, and the alternating patterns make the block's own output fall on the shared line, so any spurious recapture would show up as corrupted bits.

// File: rtl/pse_pkg.sv
package pse_pkg;

    // Direction state of the shared strobe/data line.
    typedef enum logic [0:0] {
        ST_LISTEN = 1'b0,
        ST_SEND   = 1'b1
    } pse_state_e;

endpackage

// File: rtl/pse_sync.sv
// Multi-stage synchronizer with falling-edge detection on the synchronized value.
module pse_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic level_o,
    output logic fall_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            chain_q[0] <= RST_VAL;
        end else begin
            chain_q[0] <= d_i;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                chain_q[s] <= RST_VAL;
            end else begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            prev_q <= RST_VAL;
        end else begin
            prev_q <= chain_q[LAST];
        end
    end

    assign level_o = chain_q[LAST];
    assign fall_o  = prev_q & ~chain_q[LAST];

endmodule

// File: rtl/pse_fall_counter.sv
// Counts serial clock falls since the last capture, saturating one past the word width.
module pse_fall_counter #(
    parameter int unsigned WIDTH = 12,
    parameter int unsigned CNT_W = $clog2(WIDTH + 2)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             clr_i,
    input  logic             step_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             at_end_o
);
    localparam logic [CNT_W-1:0] TERM = CNT_W'(WIDTH + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= TERM;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (step_i && (cnt_q != TERM)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o    = cnt_q;
    assign at_end_o = (cnt_q >= LAST);

endmodule

// File: rtl/pse_shifter.sv
// Capture register and serial output stage.
module pse_shifter #(
    parameter int unsigned WIDTH = 12
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic             shift_i,
    input  logic [WIDTH-1:0] par_i,
    output logic             ser_o
);
    logic [WIDTH-1:0] sreg_q;
    logic             out_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sreg_q <= '0;
            out_q  <= 1'b0;
        end else if (load_i) begin
            sreg_q <= par_i;
            out_q  <= 1'b0;
        end else if (shift_i) begin
            sreg_q <= {1'b0, sreg_q[WIDTH-1:1]};
            out_q  <= sreg_q[0];
        end
    end

    assign ser_o = out_q;

endmodule

// File: rtl/pse_ctrl.sv
// Direction state machine: T_CAPTURE (ST_LISTEN -> ST_SEND), T_RELEASE (ST_SEND -> ST_LISTEN).
module pse_ctrl
    import pse_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic line_fall_i,
    input  logic sclk_level_i,
    input  logic sclk_fall_i,
    input  logic at_end_i,
    output logic load_o,
    output logic shift_o,
    output logic oe_o
);
    pse_state_e state_q;
    pse_state_e state_d;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_LISTEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LISTEN: begin
                if (line_fall_i && sclk_level_i) begin
                    state_d = ST_SEND;
                end
            end
            ST_SEND: begin
                if (sclk_fall_i && at_end_i) begin
                    state_d = ST_LISTEN;
                end
            end
            default: state_d = ST_LISTEN;
        endcase
    end

    always_comb begin
        load_o  = 1'b0;
        shift_o = 1'b0;
        oe_o    = 1'b0;
        unique case (state_q)
            ST_LISTEN: begin
                load_o = line_fall_i && sclk_level_i;
            end
            ST_SEND: begin
                oe_o    = 1'b1;
                shift_o = sclk_fall_i && !at_end_i;
            end
            default: begin
                oe_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pio_serial_expander.sv
module pio_serial_expander #(
    parameter int unsigned WIDTH       = 12,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] par_i,
    input  logic             sclk_pin_i,
    input  logic             sline_pin_i,
    output logic             sline_pin_o,
    output logic             sline_oe_o
);
    localparam int unsigned CNT_W = $clog2(WIDTH + 2);

    logic             sclk_level;
    logic             sclk_fall;
    logic             line_level;
    logic             line_fall;
    logic             load;
    logic             shift;
    logic             at_end;
    logic [CNT_W-1:0] fall_cnt;

    pse_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk_sync (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .d_i     (sclk_pin_i),
        .level_o (sclk_level),
        .fall_o  (sclk_fall)
    );

    pse_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_line_sync (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .d_i     (sline_pin_i),
        .level_o (line_level),
        .fall_o  (line_fall)
    );

    pse_fall_counter #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_cnt (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .clr_i    (load),
        .step_i   (sclk_fall),
        .cnt_o    (fall_cnt),
        .at_end_o (at_end)
    );

    pse_ctrl u_ctrl (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .line_fall_i  (line_fall),
        .sclk_level_i (sclk_level),
        .sclk_fall_i  (sclk_fall),
        .at_end_i     (at_end),
        .load_o       (load),
        .shift_o      (shift),
        .oe_o         (sline_oe_o)
    );

    pse_shifter #(.WIDTH(WIDTH)) u_shift (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .load_i  (load),
        .shift_i (shift),
        .par_i   (par_i),
        .ser_o   (sline_pin_o)
    );

    logic unused_level;
    assign unused_level = line_level;

endmodule

// File: rtl/pse_checker.sv
module pse_checker #(
    parameter int unsigned WIDTH = 12,
    parameter int unsigned CNT_W = 4
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             oe,
    input logic             ser,
    input logic             sclk_fall,
    input logic             sclk_level,
    input logic             line_fall,
    input logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] TERM = CNT_W'(WIDTH + 1);

    // R1: reset leaves the line released
    p_reset_released_r1: assert property (@(posedge clk_i)
        rst_i |=> !oe);

    // R2, R6, R7: output enable rises only after a strobe with the clock high
    p_capture_strobe_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(oe) |-> $past(line_fall && sclk_level));

    // R3: driven low right after capture
    p_drive_low_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(oe) |-> (ser == 1'b0));

    // R4: data changes during output only follow a clock fall
    p_bit_on_fall_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (oe && $past(oe) && !$stable(ser)) |-> $past(sclk_fall));

    // R5: release happens with the counter at its terminal value
    p_release_count_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(oe) |-> (cnt == TERM));

    // R8: release is caused by a clock fall
    p_release_on_fall_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(oe) |-> $past(sclk_fall));

    // R9: counter never exceeds saturation
    p_cnt_bound_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt <= TERM);

endmodule

bind pio_serial_expander pse_checker #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .oe         (sline_oe_o),
    .ser        (sline_pin_o),
    .sclk_fall  (sclk_fall),
    .sclk_level (sclk_level),
    .line_fall  (line_fall),
    .cnt        (fall_cnt)
);

// File: tb/pio_serial_expander_tb.sv
module pio_serial_expander_tb;
    localparam int W    = 12;
    localparam int HALF = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] par = '0;
    logic         sclk = 1'b1;
    logic         host_en = 1'b0;
    logic         host_val = 1'b1;
    logic         ser;
    logic         oe;
    logic         pin;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    assign pin = oe ? ser : (host_en ? host_val : 1'b1);

    pio_serial_expander u_dut (
        .clk_i       (clk),
        .rst_i       (rst),
        .par_i       (par),
        .sclk_pin_i  (sclk),
        .sline_pin_i (pin),
        .sline_pin_o (ser),
        .sline_oe_o  (oe)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fall_clk;
        sclk = 1'b0;
        cyc(HALF);
    endtask

    task automatic rise_clk;
        sclk = 1'b1;
        cyc(HALF);
    endtask

    // Strobe with the serial clock high (R2, R3)
    task automatic capture(logic [W-1:0] w);
        par = w;
        host_en = 1'b1;
        host_val = 1'b0;
        cyc(HALF);
        host_en = 1'b0;
        host_val = 1'b1;
        check("R2 oe after capture", int'(oe), 1);
        check("R3 line low after capture", int'(pin), 0);
    endtask

    // Send n bits (R4, R6); par changes after each bit
    task automatic send_bits(logic [W-1:0] w, int n);
        for (int k = 0; k < n; k++) begin
            fall_clk();
            check("R4 serial bit", int'(pin), int'(w[k]));
            check("R5 still driving", int'(oe), 1);
            par = ~par ^ W'(k * 37);
            rise_clk();
        end
    endtask

    task automatic full_transfer(logic [W-1:0] w);
        capture(w);
        send_bits(w, W);
        fall_clk();
        check("R5 released after 13th fall", int'(oe), 0);
        rise_clk();
    endtask

    initial begin
        cyc(4);
        check("R1 oe in reset", int'(oe), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 oe after reset", int'(oe), 0);
        check("R1 output value after reset", int'(ser), 0);
        cyc(HALF);

        // Main sweep: edge patterns and arithmetic words (R4, R5, R6)
        full_transfer(12'h000);
        full_transfer(12'hFFF);
        full_transfer(12'hAAA);
        full_transfer(12'h555);
        for (int i = 0; i < W; i++) begin
            full_transfer(W'(1) << i);
            full_transfer(~(W'(1) << i));
        end
        for (int i = 0; i < 48; i++) begin
            full_transfer(W'((i * 2533 + 371) ^ (i << 5)));
        end

        // R7: strobe while the clock is low
        fall_clk();
        host_en = 1'b1;
        host_val = 1'b0;
        cyc(HALF);
        check("R7 no capture with clock low", int'(oe), 0);
        host_en = 1'b0;
        host_val = 1'b1;
        cyc(HALF);
        check("R7 still released", int'(oe), 0);
        rise_clk();
        full_transfer(12'h3C5);

        // R8: falls in input mode never enable output
        for (int i = 0; i < 20; i++) begin
            fall_clk();
            check("R8 listen stays released", int'(oe), 0);
            rise_clk();
        end

        // R8, R9: abandon a transfer after k bits, then 13 falls release it
        for (int k = 0; k <= W; k++) begin
            logic [W-1:0] w;
            w = W'(k * 911 + 77);
            capture(w);
            send_bits(w, k);
            for (int j = 0; j < 13; j++) begin
                fall_clk();
                rise_clk();
            end
            check("R8 released after 13 falls", int'(oe), 0);
            full_transfer(~w);
        end

        // R1: reset in the middle of a transfer
        capture(12'h9A6);
        send_bits(12'h9A6, 3);
        rst = 1'b1;
        cyc(3);
        check("R1 reset mid transfer", int'(oe), 0);
        rst = 1'b0;
        cyc(HALF);
        check("R1 released after reset", int'(oe), 0);
        full_transfer(12'h6D1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule